// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one compare/capture lane that sits beside a counter core. The core supplies its count value, its counting direction, single-cycle pulses for wrap at the top (overflow) and wrap at zero (underflow), and a level that says whether it is counting. From these the lane does one of three jobs, picked by a two-bit mode: it latches the count when a qualified input edge arrives (capture), it drives an output pin through programmable actions on count events (compare), or it produces a pulse-width waveform whose duty value is double-buffered (PWM).

The capture input comes from either an external pin or an internal trigger line. It passes through a two-flop synchronizer and an edge detector. Capture events can be thinned to every second capture, or limited to one edge polarity. A single register port writes the active compare value, the compare buffer, or the write-one-to-clear for the sticky event flag. While the counter is halted, the output pin shows a configured idle level. Counting resumes from that level. A final inversion can be applied to the pin.

Top module: `cc_channel`

## Requirements
- R1: After reset, `evt_flag` is 0, `ccv` is 0 and the internal output state is 0.
- R2: The capture source is `trig_in` when `input_sel`=1, otherwise `pin_in`. The unselected line has no effect. A change on the source before clock edge k is seen by the edge detector after edge k+1, so the count is latched into `ccv` at edge k+2.
- R3: Edge select `edge_sel`: 0 rising, 1 falling, 2 both. With 3 there is no edge detection, and a capture happens on every cycle in which the synchronized input is high.
- R4: Event control `evt_ctl`: 0 raises an event on every capture. 1 raises it on every second capture, with the parity restarting whenever the mode is not capture. 2 raises it only on captures of a rising edge, and 3 only on captures of a falling edge.
- R5: `evt_flag` is sticky. It is set on a qualified capture event, or on a compare match in modes 2 and 3. A write with `wr_sel`=2 and `wr_data[0]`=1 clears it. A set in the same cycle wins over the clear.
- R6: A write with `wr_sel`=0 loads `ccv` directly. A write with `wr_sel`=1 loads the buffer and marks it fresh. On an overflow or underflow pulse in mode 2 or 3, a fresh buffer moves into `ccv` and becomes stale. A stale buffer is never moved. A capture wins over a direct write, and a direct write wins over a buffer move.
- R7: In compare mode (`mode`=2) with the counter running, the output takes the action of the event: a match (`cnt_val`==`ccv`) uses `match_act`, an overflow uses `ovf_act`, an underflow uses `unf_act`. The action codes are 0 none, 1 toggle, 2 clear, 3 set. A match has priority over overflow, and overflow over underflow.
- R8: In PWM mode (`mode`=3) while counting up, the output is set at overflow and cleared at match. While counting down, it is cleared at underflow and set at match. A match has priority. A compare value above the count range gives a steady high output when counting up.
- R9: While `running`=0, `out_pin` equals `init_lvl` (after inversion), and the internal output state is loaded with `init_lvl`, so counting resumes from that level.
- R10: `out_inv`=1 inverts `out_pin` combinationally.
- R11: In mode 0 (off) and mode 1 (capture), no output action applies and the output state holds. In mode 0 no capture or event occurs, and `ccv` changes only by a direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Counter core value |
| cnt_up | input | 1 | Counter direction, 1 = up |
| ovf_pulse | input | 1 | Counter wrapped at top |
| unf_pulse | input | 1 | Counter wrapped at zero |
| running | input | 1 | Counter is counting |
| pin_in | input | 1 | External capture pin |
| trig_in | input | 1 | Internal trigger line |
| input_sel | input | 1 | 1 selects trig_in |
| mode | input | 2 | 0 off, 1 capture, 2 compare, 3 PWM |
| edge_sel | input | 2 | Capture edge selection |
| evt_ctl | input | 2 | Capture event qualification |
| match_act | input | 2 | Action on match |
| ovf_act | input | 2 | Action on overflow |
| unf_act | input | 2 | Action on underflow |
| init_lvl | input | 1 | Output level while stopped |
| out_inv | input | 1 | Invert output pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 value, 1 buffer, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| out_pin | output | 1 | Channel output |
| evt_flag | output | 1 | Sticky event flag |
| ccv | output | CNT_W | Active compare / captured value |

## Verification
A behavioural model in the bench follows the lane every cycle while the counter runs up, runs down, and stops.

Compare mode is run with toggle, set and clear actions, and with a compare value equal to the top count, so that match and overflow coincide and the priority shows. PWM is run with a buffered in-range duty, an out-of-range duty and down counting. This separates a fresh buffer from a stale one and shows the steady-high corner.

Capture mode is driven with irregular pin toggles under all sixteen edge and event combinations, and again with the trigger line selected while the pin toggles differently. This tells rising, falling and decimated events apart, and shows that the unselected source is ignored.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {CC_OFF = 2'd0, CC_CAPTURE = 2'd1, CC_COMPARE = 2'd2, CC_PWM = 2'd3} cc_mode_e;
  typedef enum logic [1:0] {EDG_RISE = 2'd0, EDG_FALL = 2'd1, EDG_BOTH = 2'd2, EDG_LEVEL = 2'd3} cc_edge_e;
  typedef enum logic [1:0] {EV_EVERY = 2'd0, EV_SECOND = 2'd1, EV_RISE = 2'd2, EV_FALL = 2'd3} cc_evt_e;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_TOGGLE = 2'd1, ACT_CLEAR = 2'd2, ACT_SET = 2'd3} cc_act_e;
  typedef enum logic [1:0] {WSEL_VALUE = 2'd0, WSEL_BUFFER = 2'd1, WSEL_FLAGCLR = 2'd2, WSEL_RSVD = 2'd3} cc_wsel_e;

  function automatic logic apply_act(input logic cur, input cc_act_e act);
    case (act)
      ACT_TOGGLE: apply_act = ~cur;
      ACT_CLEAR:  apply_act = 1'b0;
      ACT_SET:    apply_act = 1'b1;
      default:    apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/cc_in_qual.sv
module cc_in_qual
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       trig_in,
  input  logic       input_sel,
  input  logic       capture_en,
  input  logic [1:0] edge_sel,
  input  logic [1:0] evt_ctl,
  output logic       cap_hit,
  output logic       cap_evt
);
  logic src;
  logic sync1_q, sync2_q, prev_q, par_q, par_d;
  logic rise, fall, hit_raw;

  assign src  = input_sel ? trig_in : pin_in;
  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    case (cc_edge_e'(edge_sel))
      EDG_RISE: hit_raw = rise;
      EDG_FALL: hit_raw = fall;
      EDG_BOTH: hit_raw = rise | fall;
      default:  hit_raw = sync2_q;
    endcase
    cap_hit = capture_en & hit_raw;
    case (cc_evt_e'(evt_ctl))
      EV_EVERY:  cap_evt = cap_hit;
      EV_SECOND: cap_evt = cap_hit & par_q;
      EV_RISE:   cap_evt = cap_hit & rise;
      default:   cap_evt = cap_hit & fall;
    endcase
    if (!capture_en)  par_d = 1'b0;
    else if (cap_hit) par_d = ~par_q;
    else              par_d = par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      sync1_q <= src;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      par_q   <= par_d;
    end
  end
endmodule

// File: rtl/cc_val_reg.sv
module cc_val_reg
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_hit,
  input  logic             cmp_active,
  input  logic             upd_evt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] ccv
);
  logic [CNT_W-1:0] ccv_q, ccv_d, buf_q, buf_d;
  logic             fresh_q, fresh_d, load;
  logic             wr_val, wr_buf;

  assign wr_val = wr_en && (cc_wsel_e'(wr_sel) == WSEL_VALUE);
  assign wr_buf = wr_en && (cc_wsel_e'(wr_sel) == WSEL_BUFFER);
  assign load   = cmp_active & upd_evt & fresh_q;

  always_comb begin
    ccv_d   = ccv_q;
    buf_d   = buf_q;
    fresh_d = fresh_q;
    if (cap_hit)     ccv_d = cnt_val;
    else if (wr_val) ccv_d = wr_data;
    else if (load)   ccv_d = buf_q;
    if (wr_buf) begin
      buf_d   = wr_data;
      fresh_d = 1'b1;
    end else if (load) begin
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccv_q   <= '0;
      buf_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      ccv_q   <= ccv_d;
      buf_q   <= buf_d;
      fresh_q <= fresh_d;
    end
  end

  assign ccv = ccv_q;
endmodule

// File: rtl/cc_out_ctl.sv
module cc_out_ctl
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic [1:0] mode,
  input  logic       cnt_up,
  input  logic       ovf_pulse,
  input  logic       unf_pulse,
  input  logic       match,
  input  logic [1:0] match_act,
  input  logic [1:0] ovf_act,
  input  logic [1:0] unf_act,
  input  logic       init_lvl,
  input  logic       out_inv,
  output logic       out_pin
);
  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (!running) begin
      out_d = init_lvl;
    end else begin
      case (cc_mode_e'(mode))
        CC_COMPARE: begin
          if (match)          out_d = apply_act(out_q, cc_act_e'(match_act));
          else if (ovf_pulse) out_d = apply_act(out_q, cc_act_e'(ovf_act));
          else if (unf_pulse) out_d = apply_act(out_q, cc_act_e'(unf_act));
        end
        CC_PWM: begin
          if (cnt_up) begin
            if (match)          out_d = 1'b0;
            else if (ovf_pulse) out_d = 1'b1;
          end else begin
            if (match)          out_d = 1'b1;
            else if (unf_pulse) out_d = 1'b0;
          end
        end
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_pin = (running ? out_q : init_lvl) ^ out_inv;
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic             ovf_pulse,
  input  logic             unf_pulse,
  input  logic             running,
  input  logic             pin_in,
  input  logic             trig_in,
  input  logic             input_sel,
  input  logic [1:0]       mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       evt_ctl,
  input  logic [1:0]       match_act,
  input  logic [1:0]       ovf_act,
  input  logic [1:0]       unf_act,
  input  logic             init_lvl,
  input  logic             out_inv,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_pin,
  output logic             evt_flag,
  output logic [CNT_W-1:0] ccv
);
  logic capture_en, cmp_active, cap_hit, cap_evt, match, flag_clr;
  logic flag_q, flag_d;

  assign capture_en = (cc_mode_e'(mode) == CC_CAPTURE);
  assign cmp_active = (cc_mode_e'(mode) == CC_COMPARE) || (cc_mode_e'(mode) == CC_PWM);
  assign match      = running & cmp_active & (cnt_val == ccv);
  assign flag_clr   = wr_en && (cc_wsel_e'(wr_sel) == WSEL_FLAGCLR) && wr_data[0];

  cc_in_qual u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_in(trig_in),
    .input_sel(input_sel), .capture_en(capture_en), .edge_sel(edge_sel),
    .evt_ctl(evt_ctl), .cap_hit(cap_hit), .cap_evt(cap_evt)
  );

  cc_val_reg #(.CNT_W(CNT_W)) u_val (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_hit(cap_hit),
    .cmp_active(cmp_active), .upd_evt(ovf_pulse | unf_pulse), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ccv(ccv)
  );

  cc_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .running(running), .mode(mode), .cnt_up(cnt_up),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .match(match),
    .match_act(match_act), .ovf_act(ovf_act), .unf_act(unf_act),
    .init_lvl(init_lvl), .out_inv(out_inv), .out_pin(out_pin)
  );

  always_comb begin
    if (cap_evt | match) flag_d = 1'b1;
    else if (flag_clr)   flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign evt_flag = flag_q;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_up,
  input logic             ovf_pulse,
  input logic             unf_pulse,
  input logic             running,
  input logic [1:0]       mode,
  input logic             init_lvl,
  input logic             out_inv,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             out_pin,
  input logic             evt_flag,
  input logic [CNT_W-1:0] ccv
);
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (out_pin == (init_lvl ^ out_inv)));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !(wr_en && wr_sel == 2'd2 && wr_data[0])) |=> evt_flag);

  // R6
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode != 2'd1 && !ovf_pulse && !unf_pulse) |=> $stable(ccv));

  // R8
  pwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == 2'd3 && cnt_up && ovf_pulse && cnt_val != ccv)
      |=> (!running || (out_pin ^ out_inv)));

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !evt_flag) |=> !evt_flag);
endmodule

bind cc_channel cc_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cc_channel_test.sv
module cc_channel_test;
  localparam int W   = 16;
  localparam int TOP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [W-1:0] cnt_val = '0;
  logic cnt_up = 1'b1, ovf_pulse = 1'b0, unf_pulse = 1'b0, running = 1'b0;
  logic pin_in = 1'b0, trig_in = 1'b0, input_sel = 1'b0;
  logic [1:0] mode = 2'd0, edge_sel = 2'd0, evt_ctl = 2'd0;
  logic [1:0] match_act = 2'd0, ovf_act = 2'd0, unf_act = 2'd0;
  logic init_lvl = 1'b0, out_inv = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic out_pin, evt_flag;
  logic [W-1:0] ccv;

  int n_cmp = 0, n_bad = 0;
  bit run_cnt = 0, started = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_s1, m_s2, m_pv, m_par, m_flag, m_oq, m_fresh;
  int m_ccv, m_buf;

  always #5 clk = ~clk;

  cc_channel #(.CNT_W(W)) uut (.*);

  // counter core stand-in, drives at negedge + 1
  always @(negedge clk) begin
    #1;
    if (run_cnt) begin
      if (cnt_up) cnt_val = (cnt_val == TOP) ? '0 : cnt_val + 1'b1;
      else        cnt_val = (cnt_val == 0) ? W'(TOP) : cnt_val - 1'b1;
      ovf_pulse = cnt_up && (cnt_val == TOP);
      unf_pulse = !cnt_up && (cnt_val == 0);
    end else begin
      ovf_pulse = 1'b0;
      unf_pulse = 1'b0;
    end
  end

  function automatic bit act(bit cur, int a);
    if (a == 1) return !cur;
    if (a == 2) return 1'b0;
    if (a == 3) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_par = 0; m_flag = 0; m_oq = 0;
      m_fresh = 0; m_ccv = 0; m_buf = 0;
    end else begin
      bit rs, fl, hit, ev, mt, ld, cmpm, clr;
      int nccv;
      rs = m_s2 && !m_pv;
      fl = !m_s2 && m_pv;
      case (edge_sel)
        2'd0: hit = rs;
        2'd1: hit = fl;
        2'd2: hit = rs || fl;
        default: hit = m_s2;
      endcase
      hit = hit && (mode == 2'd1);
      case (evt_ctl)
        2'd0: ev = hit;
        2'd1: ev = hit && m_par;
        2'd2: ev = hit && rs;
        default: ev = hit && fl;
      endcase
      cmpm = (mode >= 2'd2);
      mt = running && cmpm && (int'(cnt_val) == m_ccv);
      ld = cmpm && (ovf_pulse || unf_pulse) && m_fresh;
      clr = wr_en && wr_sel == 2'd2 && wr_data[0];
      nccv = m_ccv;
      if (hit) nccv = cnt_val;
      else if (wr_en && wr_sel == 2'd0) nccv = wr_data;
      else if (ld) nccv = m_buf;
      if (wr_en && wr_sel == 2'd1) begin m_buf = wr_data; m_fresh = 1; end
      else if (ld) m_fresh = 0;
      if (ev || mt) m_flag = 1; else if (clr) m_flag = 0;
      if (!running) m_oq = init_lvl;
      else if (mode == 2'd2) begin
        if (mt) m_oq = act(m_oq, match_act);
        else if (ovf_pulse) m_oq = act(m_oq, ovf_act);
        else if (unf_pulse) m_oq = act(m_oq, unf_act);
      end else if (mode == 2'd3) begin
        if (cnt_up) begin
          if (mt) m_oq = 0; else if (ovf_pulse) m_oq = 1;
        end else begin
          if (mt) m_oq = 1; else if (unf_pulse) m_oq = 0;
        end
      end
      if (mode != 2'd1) m_par = 0; else if (hit) m_par = !m_par;
      m_ccv = nccv;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = input_sel ? trig_in : pin_in;
    end
  end

  task automatic check(string what, int actual, int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, actual, expected, $time);
    end
  endtask

  // per-cycle comparison at negedge, before stimulus moves
  always @(negedge clk) begin
    if (started && rst_n) begin
      check("out_pin", out_pin, (running ? m_oq : init_lvl) ^ out_inv);
      check("evt_flag", evt_flag, m_flag);
      check("ccv", ccv, m_ccv);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = W'(data);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic toggles(bit use_trig);
    for (int i = 0; i < 8; i++) begin
      if (use_trig) begin trig_in = !trig_in; pin_in = (i % 3 == 0); end
      else pin_in = !pin_in;
      cyc(3 + i % 3);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    #2 rst_n = 0;
    cyc(3);
    rst_n = 1;
    started = 1;
    cyc(1);
    cur_req = "R1";
    check("reset flag", evt_flag, 0);
    check("reset ccv", ccv, 0);
    check("reset out", out_pin, 0);

    // compare mode actions
    cur_req = "R7";
    mode = 2'd2; match_act = 2'd1; ovf_act = 2'd0;
    cur_req = "R6"; wr(0, 4); cur_req = "R7";
    running = 1; run_cnt = 1; cnt_up = 1;
    cyc(30);
    match_act = 2'd3; ovf_act = 2'd2; cyc(30);
    cnt_up = 0; match_act = 2'd0; unf_act = 2'd1; cyc(30);
    cnt_up = 1; match_act = 2'd3; ovf_act = 2'd2; wr(0, TOP); cyc(30);
    cur_req = "R5"; wr(2, 1); cyc(2); wr(2, 0); cyc(2);

    // PWM with buffered duty
    cur_req = "R8"; mode = 2'd3;
    cur_req = "R6"; wr(1, 3); cyc(25);
    cur_req = "R8"; wr(1, 12); cyc(30);
    cnt_up = 0; wr(1, 5); cyc(30);
    cnt_up = 1; cyc(20);

    // stopped level and resume
    cur_req = "R9"; init_lvl = 1; running = 0; run_cnt = 0; cyc(6);
    running = 1; run_cnt = 1; cyc(20);
    cur_req = "R10"; out_inv = 1; cyc(20);
    running = 0; run_cnt = 0; cyc(4); running = 1; run_cnt = 1; out_inv = 0; cyc(10);

    // capture: all edge / event combinations
    mode = 2'd1; wr(2, 1);
    for (int es = 0; es < 4; es++) begin
      for (int ec = 0; ec < 4; ec++) begin
        cur_req = (ec == 0) ? "R3" : "R4";
        edge_sel = 2'(es); evt_ctl = 2'(ec);
        toggles(0);
        cur_req = "R5"; wr(2, 1); cyc(2);
      end
    end
    cur_req = "R2"; edge_sel = 2'd0; evt_ctl = 2'd0; input_sel = 1;
    toggles(1); wr(2, 1); toggles(1);
    input_sel = 0; pin_in = 0; trig_in = 0; cyc(4);

    // flag set and clear in the same cycle
    cur_req = "R5"; edge_sel = 2'd3; pin_in = 1; cyc(4); wr(2, 1); cyc(2); pin_in = 0; cyc(4);
    wr(2, 1); cyc(2);

    // off mode: no capture, no load, output holds
    cur_req = "R11"; mode = 2'd0; edge_sel = 2'd0;
    wr(1, 7); toggles(0); cyc(20);
    cur_req = "R6"; wr(0, 2); cyc(3);
    cur_req = "R11"; mode = 2'd1; cyc(4); mode = 2'd0; toggles(0);
    cur_req = "R6"; mode = 2'd2; cyc(25);

    done = 1;
    summary();
  end
endmodule